// File: doc/BRIEF.md
# Programmable Cycle Delay Timer

This block lets a sequencing controller pause for an exact number of clock cycles. The controller places a cycle count on `count` and raises `go`. The timer captures the count when it accepts the request, counts rising clock edges, and then raises `done` for a pulse of fixed length.

The two sides follow a four-phase handshake. The requester lowers `go` once it sees `done` high, and it waits for `done` to fall before it asks again. The timer accepts a request only from its idle state. It does not return to idle until `go` has been observed low. If `go` stays high the whole time, the timer runs one delay only and does not restart.

The counter is 20 bits wide by default, so it covers waits of 750000 cycles and more. Short waits are exact to the cycle.

Top module: `cycDelayTimer`

## Requirements
- R1: `rst` is synchronous and active high. While `rst` is high, and on the cycle after it is released, `done` is low and `go` has no effect. A reset in the middle of a delay aborts that delay, and no `done` follows from it.
- R2: When `go` is sampled high at rising edge k while the timer is idle, the timer captures `count` (value N ≥ 1) and `done` rises at edge k+N. This holds for N = 1, 5, 10 and 20.
- R3: A captured `count` of 0 is treated as 1, so `done` rises at edge k+1.
- R4: `done` stays high for exactly 3 cycles and then falls, whether `go` is high or low during that time.
- R5: `go` and `count` are sampled only in the idle state. Dropping `go` or changing `count` during a delay does not alter the delay.
- R6: If `go` is held high through the whole pulse, `done` stays low afterwards and no new delay starts until `go` has been low for at least one edge.
- R7: If `go` was low at any edge during the `done` pulse, the timer is idle on the edge at which `done` falls. A request raised right after that edge is therefore accepted on the next edge.
- R8: With the default width of 20 bits, a long wait (120000 cycles in the bench) is counted exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| count | input | CNT_W (20) | Requested delay in cycles; 0 is treated as 1 |
| go | input | 1 | Start request, sampled only when idle |
| done | output | 1 | Completion flag, a 3-cycle pulse |

## Verification
Each request has a computed due edge. If `go` is sampled at edge k, `done` is due to rise at edge k+max(N,1) and to fall three edges later. The driver computes the due edge from the number of posedges it has counted. It pushes that edge into a queue, and the monitor compares it against the edge at which it sees `done` change. All sampling happens on the falling edge, so every observation falls half a cycle after the register that changed it. Any rise of `done` while the queue is empty counts as a failure, and this is how restarts that should not happen are caught.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COUNT   = 2'd1,
    ST_PULSE   = 2'd2,
    ST_WAIT_LO = 2'd3
  } tmrState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadDelay;
    logic decDelay;
    logic clrPulse;
    logic incPulse;
  } tmrStrobe_t;
endpackage

// File: rtl/cdtDatapath.sv
module cdtDatapath
  import cdt_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] count,
  output logic             delayLast,
  output logic             pulseLast
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PULSE_END = PW'(PULSE_LEN - 1);

  logic [CNT_W-1:0] remainQ;
  logic [PW-1:0]    pulseCntQ;
  logic [CNT_W-1:0] loadVal;

  // A zero request is promoted to a single cycle
  assign loadVal = (count == '0) ? CNT_W'(1) : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      remainQ <= '0;
    end else if (strobe.loadDelay) begin
      remainQ <= loadVal;
    end else if (strobe.decDelay) begin
      remainQ <= remainQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseCntQ <= '0;
    end else if (strobe.clrPulse) begin
      pulseCntQ <= '0;
    end else if (strobe.incPulse) begin
      pulseCntQ <= pulseCntQ + PW'(1);
    end
  end

  assign delayLast = (remainQ == CNT_W'(1));
  assign pulseLast = (pulseCntQ == PULSE_END);

  // R3: a loaded delay is never zero
  p_load_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.loadDelay |=> (remainQ != '0));

  // R2: each counting cycle removes exactly one from the remainder
  p_dec_step_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.decDelay && !strobe.loadDelay) |=> (remainQ == $past(remainQ) - CNT_W'(1)));
endmodule

// File: rtl/cdtControl.sv
module cdtControl
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       delayLast,
  input  logic       pulseLast,
  output tmrStrobe_t strobe,
  output logic       done
);
  tmrState_e stateQ, stateD;
  logic      doneQ, doneD;
  logic      goLowSeenQ, goLowSeenD;

  always_comb begin
    stateD     = stateQ;
    doneD      = doneQ;
    goLowSeenD = goLowSeenQ;
    strobe     = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (go) begin
          strobe.loadDelay = 1'b1;
          stateD           = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (delayLast) begin
          strobe.clrPulse = 1'b1;
          doneD           = 1'b1;
          goLowSeenD      = 1'b0;
          stateD          = ST_PULSE;
        end else begin
          strobe.decDelay = 1'b1;
        end
      end
      ST_PULSE: begin
        strobe.incPulse = 1'b1;
        if (!go) goLowSeenD = 1'b1;
        if (pulseLast) begin
          doneD  = 1'b0;
          stateD = (goLowSeenQ || !go) ? ST_IDLE : ST_WAIT_LO;
        end
      end
      ST_WAIT_LO: begin
        if (!go) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ     <= ST_IDLE;
      doneQ      <= 1'b0;
      goLowSeenQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      doneQ      <= doneD;
      goLowSeenQ <= goLowSeenD;
    end
  end

  assign done = doneQ;

  // R4: the done pulse lasts exactly three cycles
  p_done_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(doneQ) |=> doneQ ##1 doneQ ##1 !doneQ);

  // R6: no completion while waiting for go to drop
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAIT_LO) |=> !doneQ);

  // R1: done is never high when the timer is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE) |-> !doneQ);
endmodule

// File: rtl/cycDelayTimer.sv
module cycDelayTimer #(
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             go,
  output logic             done
);
  import cdt_pkg::*;

  tmrStrobe_t strobe;
  logic       delayLast;
  logic       pulseLast;

  cdtControl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .delayLast (delayLast),
    .pulseLast (pulseLast),
    .strobe    (strobe),
    .done      (done)
  );

  cdtDatapath #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .count     (count),
    .delayLast (delayLast),
    .pulseLast (pulseLast)
  );
endmodule

// File: tb/cycDelayTimer_tb.sv
module cycDelayTimer_tb;
  localparam int CNT_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] count = '0;
  logic             go = 1'b0;
  logic             done;

  int unsigned edgeCnt = 0;
  int          nChecks = 0;
  int          nErrors = 0;
  bit          finished = 1'b0;

  typedef struct {
    int unsigned riseEdge;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  cycDelayTimer #(.CNT_W(CNT_W)) u_dut (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .go    (go),
    .done  (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d at edge %0d", tag, act, exp, edgeCnt);
    end
  endtask

  // Monitor: compares rise edge and pulse width against the scoreboard
  logic        prevDone = 1'b0;
  int unsigned riseAt = 0;
  always @(negedge clk) begin
    if (rst) begin
      prevDone <= 1'b0;
    end else begin
      if (done && !prevDone) begin
        riseAt = edgeCnt;
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected done", int'(edgeCnt), 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(edgeCnt == it.riseEdge, it.tag, int'(edgeCnt), int'(it.riseEdge));
        end
      end
      if (!done && prevDone) begin
        check(edgeCnt - riseAt == 3, "R4 done width", int'(edgeCnt - riseAt), 3);
      end
      prevDone <= done;
    end
  end

  // Driver: raise go at a negedge; it is sampled at the next edge
  task automatic startReq(input int n, input string tag);
    int eff;
    eff = (n == 0) ? 1 : n;
    count = CNT_W'(n);
    go    = 1'b1;
    expQ.push_back('{riseEdge: edgeCnt + 1 + eff, tag: tag});
  endtask

  task automatic waitDoneHigh();
    while (!done) @(negedge clk);
  endtask

  task automatic waitDoneLow();
    while (done) @(negedge clk);
  endtask

  // Full handshake: request, drop go on done, wait for done low
  task automatic handshake(input int n, input string tag);
    startReq(n, tag);
    @(negedge clk);
    waitDoneHigh();
    go = 1'b0;
    waitDoneLow();
  endtask

  initial begin
    // R1: reset holds done low even with go high
    @(negedge clk);
    go = 1'b1; count = CNT_W'(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R1 done in reset", done, 0);
    end
    go = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    @(negedge clk);

    // R2: exact short waits
    handshake(5,  "R2 latency 5");
    @(negedge clk);
    handshake(10, "R2 latency 10");
    @(negedge clk);
    handshake(20, "R2 latency 20");
    @(negedge clk);
    handshake(1,  "R2 latency 1");
    @(negedge clk);

    // R3: zero acts as one
    handshake(0, "R3 zero count");
    // R7: raise go at once after done falls
    handshake(7, "R7 back to back");
    handshake(3, "R7 back to back second");
    @(negedge clk);

    // R5: one-cycle go, count changed mid-delay
    startReq(10, "R5 go dropped early");
    @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    count = CNT_W'(2);
    waitDoneHigh();
    count = '0;
    waitDoneLow();
    @(negedge clk);

    // R6: go held high across and after the pulse
    startReq(4, "R6 held go latency");
    @(negedge clk);
    waitDoneHigh();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 3) check(done == 1'b0, "R6 no restart while go high", done, 0);
    end
    go = 1'b0;
    @(negedge clk);
    handshake(6, "R6 restart after go low");
    @(negedge clk);

    // R1: reset in the middle of a delay aborts it
    count = CNT_W'(20); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (i % 5 == 0) check(done == 1'b0, "R1 aborted delay", done, 0);
    end

    // R8: long wait
    handshake(120000, "R8 long wait");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", edgeCnt, 0);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule